// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block is the control core of the transmit half of a descriptor-ring DMA engine. Once started, it loops over a ring of transmit descriptors. For each one it asks a descriptor reader for the next entry and checks who owns it. It then has a data mover copy the buffer into the transmit FIFO, waits for the MAC to report the end of the frame, and asks for the descriptor to be written back before it moves on to the next entry. The memory bus and the MAC sit outside the block. They are seen only through request/grant pairs and an end-of-transmission strobe.

The current phase appears on a 3-bit code that the host can read, so the code values are fixed. A descriptor still held by the host does not stop the engine. It parks in a suspended phase until software issues a poll demand. Three one-cycle event pulses feed a status register: frame done, buffer unavailable and process stopped. A stop command is honoured only at a point where no memory transaction is open. A stop that arrives while a frame is in flight lets that frame finish and be written back first.

Top module: `tx_desc_seq`

## Requirements
- R1: After reset the phase code is 000, no request output is high and no event pulse is high.
- R2: In phase 000, a start without a simultaneous stop moves the phase to 001 on the next edge. A start in any other phase has no effect.
- R3: With owned descriptors the phase runs 001 (descriptor request high), 011 (data request high), 010, 111 (write-back request high), then 001 again. Each phase with a request holds until its grant arrives, and it advances on the edge that samples the grant.
- R4: Phase 010 holds until the end-of-transmission input is sampled high, then moves to 111.
- R5: When a descriptor grant is sampled with ownership low (and no stop pending), the phase becomes 110 and the buffer-unavailable event is high for exactly that one cycle.
- R6: In phase 110 a poll demand returns the phase to 001. Poll has no effect in any other phase.
- R7: The frame-done event is high for exactly one cycle, in the cycle after the write-back grant is sampled.
- R8: A stop seen while in 001 takes effect at that phase's grant. A stop seen in 011, 010 or 111 lets the frame run on, and the engine goes to 000 at the write-back grant. A stop in 110 goes to 000 on the next edge and takes priority over poll.
- R9: Entering 000 from any other phase raises the stopped event for one cycle. A stop in 000 does nothing. Start and stop together in 000 leave the phase at 000.
- R10: The codes 100 and 101 never appear on the phase output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| poll_i | input | 1 | Poll demand, resumes from suspended |
| desc_req_o | output | 1 | Descriptor read request |
| desc_gnt_i | input | 1 | Descriptor read complete |
| desc_own_i | input | 1 | Descriptor is owned by the engine, valid with desc_gnt_i |
| data_req_o | output | 1 | Buffer-to-FIFO move request |
| data_gnt_i | input | 1 | Buffer move complete |
| eot_i | input | 1 | End of transmission from the MAC |
| wb_req_o | output | 1 | Descriptor write-back request |
| wb_gnt_i | input | 1 | Write-back complete |
| state_o | output | 3 | Phase code visible to the host |
| evt_done_o | output | 1 | Frame-done pulse |
| evt_unavail_o | output | 1 | Buffer-unavailable pulse |
| evt_stopped_o | output | 1 | Process-stopped pulse |

## Verification
Frame completion and a stop can land in the same cycle. A stop raised during the data-move, wait or write-back phase has to be held until the write-back grant. At that edge the frame-done and stopped pulses then rise together, and the phase goes to 000 rather than 001. The bench injects a stop at each phase, for every grant latency from zero to two cycles and for owned and unowned descriptors. At the completing edge it checks both pulses and the phase code against the value that the phase of injection predicts. A second collision, start and stop together in phase 000, is driven after every stop and must leave the engine stopped.

// File: rtl/txds_pkg.sv
package txds_pkg;
   localparam int unsigned TXS_W = 3;

   typedef enum logic [TXS_W-1:0] {
      TXS_IDLE  = 3'b000,
      TXS_FETCH = 3'b001,
      TXS_WAIT  = 3'b010,
      TXS_READ  = 3'b011,
      TXS_SUSP  = 3'b110,
      TXS_CLOSE = 3'b111
   } txs_e;

   typedef struct packed {
      logic done;
      logic unavail;
      logic stopped;
   } txs_evt_t;
endpackage

// File: rtl/txds_stop_latch.sv
module txds_stop_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_i,
   input  logic idle_i,
   input  logic enter_idle_i,
   output logic stop_eff_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pend_q <= 1'b0;
      else if (idle_i || enter_idle_i) pend_q <= 1'b0;
      else if (stop_i)                pend_q <= 1'b1;
   end

   assign stop_eff_o = pend_q | (stop_i & ~idle_i);

   AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !idle_i && !enter_idle_i) |=> pend_q); // R8
endmodule

// File: rtl/txds_fsm.sv
module txds_fsm
   import txds_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             stop_eff_i,
   input  logic             poll_i,
   input  logic             desc_gnt_i,
   input  logic             desc_own_i,
   input  logic             data_gnt_i,
   input  logic             eot_i,
   input  logic             wb_gnt_i,
   output txs_e             state_o,
   output logic             enter_idle_o,
   output txs_evt_t         fire_o,
   output logic             desc_req_o,
   output logic             data_req_o,
   output logic             wb_req_o
);
   txs_e state_q, nxt;

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         TXS_IDLE:  if (start_i && !stop_i) nxt = TXS_FETCH;
         TXS_FETCH: if (desc_gnt_i) begin
                       if (stop_eff_i)      nxt = TXS_IDLE;
                       else if (desc_own_i) nxt = TXS_READ;
                       else                 nxt = TXS_SUSP;
                    end
         TXS_READ:  if (data_gnt_i) nxt = TXS_WAIT;
         TXS_WAIT:  if (eot_i)      nxt = TXS_CLOSE;
         TXS_CLOSE: if (wb_gnt_i)   nxt = stop_eff_i ? TXS_IDLE : TXS_FETCH;
         TXS_SUSP:  if (stop_eff_i) nxt = TXS_IDLE;
                    else if (poll_i) nxt = TXS_FETCH;
         default:   nxt = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TXS_IDLE;
      else        state_q <= nxt;
   end

   assign enter_idle_o   = (nxt == TXS_IDLE) && (state_q != TXS_IDLE);
   assign fire_o.done    = (state_q == TXS_CLOSE) && wb_gnt_i;
   assign fire_o.unavail = (state_q == TXS_FETCH) && (nxt == TXS_SUSP);
   assign fire_o.stopped = enter_idle_o;
   assign desc_req_o     = (state_q == TXS_FETCH);
   assign data_req_o     = (state_q == TXS_READ);
   assign wb_req_o       = (state_q == TXS_CLOSE);
   assign state_o        = state_q;

   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TXS_FETCH && !desc_gnt_i) |=> state_q == TXS_FETCH); // R3
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TXS_READ && !data_gnt_i) |=> state_q == TXS_READ); // R3
   AST_WAIT_EOT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TXS_WAIT && !eot_i) |=> state_q == TXS_WAIT); // R4
   AST_SUSP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TXS_SUSP && $past(state_q) != TXS_SUSP) |-> $past(state_q) == TXS_FETCH); // R5
   AST_SUSP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TXS_SUSP && stop_i) |=> state_q == TXS_IDLE); // R8
endmodule

// File: rtl/txds_evt.sv
module txds_evt
   import txds_pkg::*;
#(
   parameter bit EVT_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  txs_evt_t fire_i,
   output txs_evt_t evt_o
);
   generate
      if (EVT_REG) begin : g_reg
         txs_evt_t evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= '0;
            else        evt_q <= fire_i;
         end
         assign evt_o = evt_q;
         AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            evt_q.done |=> !evt_q.done); // R7
      end else begin : g_comb
         assign evt_o = fire_i;
      end
   endgenerate
endmodule

// File: rtl/tx_desc_seq.sv
module tx_desc_seq
   import txds_pkg::*;
#(
   parameter int unsigned STATE_W = 3,
   parameter bit          EVT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               poll_i,
   output logic               desc_req_o,
   input  logic               desc_gnt_i,
   input  logic               desc_own_i,
   output logic               data_req_o,
   input  logic               data_gnt_i,
   input  logic               eot_i,
   output logic               wb_req_o,
   input  logic               wb_gnt_i,
   output logic [STATE_W-1:0] state_o,
   output logic               evt_done_o,
   output logic               evt_unavail_o,
   output logic               evt_stopped_o
);
   localparam bit STATE_W_OK = (STATE_W == TXS_W);

   generate
      if (!STATE_W_OK) begin : g_bad_w
         $error("tx_desc_seq: STATE_W must equal the package code width");
      end
   endgenerate

   txs_e     state;
   txs_evt_t fire, evt;
   logic     stop_eff, enter_idle;

   txds_stop_latch u_stop (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_i       (stop_i),
      .idle_i       (state == TXS_IDLE),
      .enter_idle_i (enter_idle),
      .stop_eff_o   (stop_eff)
   );

   txds_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .stop_i       (stop_i),
      .stop_eff_i   (stop_eff),
      .poll_i       (poll_i),
      .desc_gnt_i   (desc_gnt_i),
      .desc_own_i   (desc_own_i),
      .data_gnt_i   (data_gnt_i),
      .eot_i        (eot_i),
      .wb_gnt_i     (wb_gnt_i),
      .state_o      (state),
      .enter_idle_o (enter_idle),
      .fire_o       (fire),
      .desc_req_o   (desc_req_o),
      .data_req_o   (data_req_o),
      .wb_req_o     (wb_req_o)
   );

   txds_evt #(.EVT_REG(EVT_REG)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire),
      .evt_o  (evt)
   );

   assign state_o       = STATE_W'(state);
   assign evt_done_o    = evt.done;
   assign evt_unavail_o = evt.unavail;
   assign evt_stopped_o = evt.stopped;

   AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[2:1] != 2'b10); // R10
   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({desc_req_o, data_req_o, wb_req_o})); // R3
   generate
      if (EVT_REG) begin : g_evt_chk
         AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            evt_done_o |-> $past(wb_req_o && wb_gnt_i)); // R7
         AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (state_o == 3'b000 && $past(state_o) != 3'b000) |-> evt_stopped_o); // R9
         AST_UNAV_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
            evt_unavail_o |-> state_o == 3'b110); // R5
      end
   endgenerate
endmodule

// File: tb/tx_desc_seq_tb.sv
`timescale 1ns/1ps
module tx_desc_seq_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 0, stop = 0, poll = 0;
   logic dgnt = 0, down = 0, xgnt = 0, eot = 0, wgnt = 0;
   logic dreq, xreq, wreq, edone, eunav, estop;
   logic [2:0] st;
   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   tx_desc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .poll_i(poll),
      .desc_req_o(dreq), .desc_gnt_i(dgnt), .desc_own_i(down),
      .data_req_o(xreq), .data_gnt_i(xgnt), .eot_i(eot),
      .wb_req_o(wreq), .wb_gnt_i(wgnt), .state_o(st),
      .evt_done_o(edone), .evt_unavail_o(eunav), .evt_stopped_o(estop)
   );

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic chk(input int act, input int exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
      if (st == 3'b100 || st == 3'b101) begin
         n_bad++;
         $display("FAIL R10 reserved code: actual %0d expected not 4/5", st);
      end
   endtask

   task automatic stop_pulse(input int code);
      stop = 1; cyc(); stop = 0;
      chk(st, code, "R8 stop waits for handshake");
   endtask

   // From phase 001; returns with phase 001 or 000
   task automatic run_frame(input int own, input int d, input int sat);
      if (sat == 1) stop_pulse(1);
      for (int k = 0; k < d; k++) begin
         if (k == 0) start = 1;
         cyc(); start = 0;
         chk(st, 1, "R2/R3 fetch held, start ignored");
         chk(dreq, 1, "R3 desc request");
      end
      dgnt = 1; down = own[0]; cyc(); dgnt = 0; down = 0;
      if (sat == 1) begin
         chk(st, 0, "R8 stop at fetch grant");
         chk(estop, 1, "R9 stopped pulse");
         chk(eunav, 0, "R8 no unavail on stop");
         return;
      end
      if (own == 0) begin
         chk(st, 6, "R5 suspend");
         chk(eunav, 1, "R5 unavail pulse");
         cyc();
         chk(eunav, 0, "R5 unavail one cycle");
         chk(st, 6, "R6 stays suspended");
         if (sat == 5) begin
            stop = 1; poll = 1; cyc(); stop = 0; poll = 0;
            chk(st, 0, "R8 stop in suspend beats poll");
            chk(estop, 1, "R9 stopped pulse");
            return;
         end
         poll = 1; cyc(); poll = 0;
         chk(st, 1, "R6 poll resumes");
         dgnt = 1; down = 1; cyc(); dgnt = 0; down = 0;
      end
      chk(st, 3, "R3 read phase");
      chk(eunav, 0, "R5 no unavail when owned");
      if (sat == 2) stop_pulse(3);
      for (int k = 0; k < d; k++) begin
         if (k == 0) poll = 1;
         cyc(); poll = 0;
         chk(st, 3, "R6 poll ignored, read held");
         chk(xreq, 1, "R3 data request");
      end
      xgnt = 1; cyc(); xgnt = 0;
      chk(st, 2, "R3 wait phase");
      if (sat == 3) stop_pulse(2);
      for (int k = 0; k < d; k++) begin
         cyc();
         chk(st, 2, "R4 wait for eot");
      end
      eot = 1; cyc(); eot = 0;
      chk(st, 7, "R4 eot to close");
      chk(wreq, 1, "R3 wb request");
      if (sat == 4) stop_pulse(7);
      for (int k = 0; k < d; k++) begin
         cyc();
         chk(st, 7, "R3 close held");
         chk(edone, 0, "R7 no early done");
      end
      wgnt = 1; cyc(); wgnt = 0;
      chk(edone, 1, "R7 done pulse");
      if (sat >= 2 && sat <= 4) begin
         chk(st, 0, "R8 stop after close");
         chk(estop, 1, "R9 stopped with done");
      end else begin
         chk(st, 1, "R3 next fetch");
         chk(estop, 0, "R9 no stopped pulse");
      end
      cyc();
      chk(edone, 0, "R7 done one cycle");
      chk(estop, 0, "R9 stopped one cycle");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      chk(st, 0, "R1 reset phase");
      chk({dreq, xreq, wreq}, 0, "R1 no requests");
      chk({edone, eunav, estop}, 0, "R1 no events");
      poll = 1; dgnt = 1; cyc(); poll = 0; dgnt = 0;
      chk(st, 0, "R6 poll ignored in stopped");
      for (int d = 0; d < 3; d++)
         for (int own = 0; own < 2; own++)
            for (int sat = 0; sat < 6; sat++) begin
               if (sat == 5 && own == 1) continue;
               if (st == 3'd0) begin
                  start = 1; cyc(); start = 0;
                  chk(st, 1, "R2 start to fetch");
               end
               run_frame(own, d, sat);
               if (st == 3'd0) begin
                  stop = 1; cyc(); stop = 0;
                  chk(st, 0, "R9 stop in stopped");
                  chk(estop, 0, "R9 no pulse when stopped");
                  start = 1; stop = 1; cyc(); start = 0; stop = 0;
                  chk(st, 0, "R9 start with stop stays stopped");
               end
            end
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule